// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 32 interrupt sources and hands a processor one request line together with the address of the handler to run. Each source can be raised in two ways: a hardware input that is held at a level, or a software bit written through the register port. The hardware and software requests are combined with OR and then gated by a per-source enable mask. Among the sources that remain, the one with the smallest index wins.

For the winner the block computes a vector table address. This is a programmable base plus the winner's index times an entry stride, and the stride is a power of two chosen in a small configuration register. Enable bits and software bits each have a direct register and two alias registers. One alias sets the bits written as one and the other clears them, so software can change one source without a read-modify-write. Each source also has its own 13-bit configuration word, which is stored and read back but does not affect arbitration.

All state is held in registers. Pending, winner selection, vector address, status and the upstream request are derived combinationally from that state. The hardware inputs are sampled once per clock, so a change on an input reaches the request line one cycle later. The register port is a single-cycle 32-bit word port. Writes take effect at the clock edge, and read data is combinational from the word address.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, including the enables and the software bits, and `irq_req` is low.
- R2: Word offsets 0..31 are per-source configuration words. A write keeps only bits [12:0], and a read returns them zero-extended.
- R3: Offset 32 holds the enable mask and a write replaces it. A write to offset 33 ORs the data into the mask. A write to offset 34 clears the mask bits where the data is one.
- R4: Offset 37 holds the software request bits and a write replaces them. A write to offset 38 ORs the data into them. A write to offset 39 clears the bits where the data is one.
- R5: Offset 36 reads the hardware input levels sampled at the previous clock edge. Bit i is input i.
- R6: Offset 35 reads pending, which is (hardware levels OR software bits) AND enable.
- R7: When several sources are pending, the lowest-numbered one is selected.
- R8: Offset 43 reads the vector address. It is base (offset 42) plus index × (4 << stride[2:0]), computed modulo 2^32. The stride register at offset 40 keeps only bits [3:0].
- R9: While any source is pending, offset 41 reads bit 31 set with the winner index in bits [4:0], and `irq_req` is high.
- R10: While nothing is pending, offsets 41 and 43 read zero and `irq_req` is low.
- R11: Writes to offsets 35, 36, 41 and 43 change nothing. Offsets 44..63 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 32 | Level-sensitive hardware interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Word offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_req | output | 1 | Upstream interrupt request |

## Verification
A corrupted enable mask or software register appears at once in the pending word and in `irq_req`, in the cycle after the faulty write. A wrong priority choice or stride shows as a wrong index in the status word or a wrong vector address. This is visible in the same cycle the state changes, because selection and address are combinational from registers. A hardware input that is mis-sampled shows in the raw word and the request exactly one edge after the input moves. For that reason the bench reads pending, status and vector address after every random step.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int VIC_NSRC  = 32;
    localparam int VIC_DW    = 32;
    localparam int VIC_CFG_W = 13;
    localparam int VIC_IDX_W = $clog2(VIC_NSRC);
    localparam int VIC_CCFG_W = 4;

    // Word offsets; fixed because software decodes them.
    localparam logic [5:0] OFF_EN     = 6'd32;
    localparam logic [5:0] OFF_ENSET  = 6'd33;
    localparam logic [5:0] OFF_ENCLR  = 6'd34;
    localparam logic [5:0] OFF_PEND   = 6'd35;
    localparam logic [5:0] OFF_RAW    = 6'd36;
    localparam logic [5:0] OFF_SW     = 6'd37;
    localparam logic [5:0] OFF_SWSET  = 6'd38;
    localparam logic [5:0] OFF_SWCLR  = 6'd39;
    localparam logic [5:0] OFF_STRIDE = 6'd40;
    localparam logic [5:0] OFF_STAT   = 6'd41;
    localparam logic [5:0] OFF_BASE   = 6'd42;
    localparam logic [5:0] OFF_VADDR  = 6'd43;

    typedef struct packed {
        logic [VIC_NSRC-1:0][VIC_CFG_W-1:0] cfg;
        logic [VIC_NSRC-1:0]                en;
        logic [VIC_NSRC-1:0]                sw;
        logic [VIC_NSRC-1:0]                raw;
        logic [VIC_DW-1:0]                  base;
        logic [VIC_CCFG_W-1:0]              stride;
    } vic_state_t;
endpackage

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        // Scan downward so the lowest set bit is assigned last and wins.
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vic_vec_gen.sv
module vic_vec_gen #(
    parameter int DW = 32,
    parameter int IW = 5
) (
    input  logic          hit,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] base,
    input  logic [2:0]    stride_log,
    output logic [DW-1:0] vaddr,
    output logic [DW-1:0] status
);
    logic [4:0] shamt;

    always_comb begin
        // Entry size is 4 << stride_log, so the index shifts by stride_log + 2.
        shamt = {2'b00, stride_log} + 5'd2;
        if (hit) begin
            vaddr  = base + (DW'(idx) << shamt);
            status = {1'b1, {(DW-1-IW){1'b0}}, idx};
        end else begin
            vaddr  = '0;
            status = '0;
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [VIC_NSRC-1:0] src_lvl,
    input  logic                wr_en,
    input  logic [AW-1:0]       addr,
    input  logic [VIC_DW-1:0]   wdata,
    output logic [VIC_DW-1:0]   rdata,
    output logic                irq_req
);
    localparam int CFG_SPAN = VIC_NSRC;

    vic_state_t st_d, st_q;

    logic [VIC_NSRC-1:0]  pend;
    logic                 win_hit;
    logic [VIC_IDX_W-1:0] win_idx;
    logic [VIC_DW-1:0]    vaddr, status;
    logic                 in_cfg;

    assign in_cfg = (32'(addr) < CFG_SPAN);

    // Next-state logic
    always_comb begin
        st_d     = st_q;
        st_d.raw = src_lvl;
        if (wr_en) begin
            if (in_cfg) begin
                st_d.cfg[addr[VIC_IDX_W-1:0]] = wdata[VIC_CFG_W-1:0];
            end else begin
                case (addr)
                    OFF_EN:     st_d.en     = wdata;
                    OFF_ENSET:  st_d.en     = st_q.en | wdata;
                    OFF_ENCLR:  st_d.en     = st_q.en & ~wdata;
                    OFF_SW:     st_d.sw     = wdata;
                    OFF_SWSET:  st_d.sw     = st_q.sw | wdata;
                    OFF_SWCLR:  st_d.sw     = st_q.sw & ~wdata;
                    OFF_STRIDE: st_d.stride = wdata[VIC_CCFG_W-1:0];
                    OFF_BASE:   st_d.base   = wdata;
                    default:    ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = (st_q.raw | st_q.sw) & st_q.en;

    vic_prio_enc #(.N(VIC_NSRC), .IW(VIC_IDX_W)) u_prio (
        .req (pend),
        .hit (win_hit),
        .idx (win_idx)
    );

    vic_vec_gen #(.DW(VIC_DW), .IW(VIC_IDX_W)) u_vec (
        .hit        (win_hit),
        .idx        (win_idx),
        .base       (st_q.base),
        .stride_log (st_q.stride[2:0]),
        .vaddr      (vaddr),
        .status     (status)
    );

    assign irq_req = |pend;

    // Read mux
    always_comb begin
        rdata = '0;
        if (in_cfg) begin
            rdata = VIC_DW'(st_q.cfg[addr[VIC_IDX_W-1:0]]);
        end else begin
            case (addr)
                OFF_EN:     rdata = st_q.en;
                OFF_PEND:   rdata = pend;
                OFF_RAW:    rdata = st_q.raw;
                OFF_SW:     rdata = st_q.sw;
                OFF_STRIDE: rdata = VIC_DW'(st_q.stride);
                OFF_STAT:   rdata = status;
                OFF_BASE:   rdata = st_q.base;
                OFF_VADDR:  rdata = vaddr;
                default:    rdata = '0;
            endcase
        end
    end

    // R3
    enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_ENSET) |=> ((st_q.en & $past(wdata)) == $past(wdata)));

    // R4
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_SWCLR) |=> ((st_q.sw & $past(wdata)) == '0));

    // R7
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend[win_idx] &&
                     ((pend & ((VIC_NSRC'(1) << win_idx) - VIC_NSRC'(1))) == '0)));

    // R9
    req_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == status[VIC_DW-1]);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (vaddr == '0 && status == '0));

    // R11
    ro_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFF_VADDR || addr == OFF_STAT)) |=> $stable(st_q.base));
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_lvl = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_req;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model
    logic [12:0] m_cfg [32];
    logic [31:0] m_en, m_sw, m_raw, m_base;
    logic [3:0]  m_stride;

    vec_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_req(irq_req)
    );

    always #5 clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    function automatic logic [31:0] m_pend();
        return (m_raw | m_sw) & m_en;
    endfunction

    function automatic int m_win();
        logic [31:0] p = m_pend();
        for (int i = 0; i < 32; i++) if (p[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] m_read(input logic [5:0] a);
        int w = m_win();
        if (a < 6'd32) return {19'd0, m_cfg[a[4:0]]};
        case (a)
            6'd32: return m_en;
            6'd35: return m_pend();
            6'd36: return m_raw;
            6'd37: return m_sw;
            6'd40: return {28'd0, m_stride};
            6'd41: return (w < 0) ? 32'd0 : (32'h8000_0000 | 32'(w));
            6'd42: return m_base;
            6'd43: return (w < 0) ? 32'd0 :
                          m_base + 32'(w) * (32'd4 << m_stride[2:0]);
            default: return 32'd0;
        endcase
    endfunction

    task automatic m_write(input logic [5:0] a, input logic [31:0] d);
        if (a < 6'd32) m_cfg[a[4:0]] = d[12:0];
        else case (a)
            6'd32: m_en = d;
            6'd33: m_en = m_en | d;
            6'd34: m_en = m_en & ~d;
            6'd37: m_sw = d;
            6'd38: m_sw = m_sw | d;
            6'd39: m_sw = m_sw & ~d;
            6'd40: m_stride = d[3:0];
            6'd42: m_base = d;
            default: ;
        endcase
    endtask

    // One clock step with an optional write; inputs driven after the falling edge.
    task automatic step(input logic [31:0] lvl, input logic do_wr,
                        input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        src_lvl = lvl;
        wr_en   = do_wr;
        addr    = a;
        wdata   = d;
        @(posedge clk);
        m_raw = lvl;
        if (do_wr) m_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [5:0] a, input string req);
        logic [31:0] exp;
        addr = a;
        #1;
        exp = m_read(a);
        n_tests++;
        if (rdata !== exp) begin
            n_fail++;
            $display("FAIL %s off=%0d actual=%h expected=%h", req, a, rdata, exp);
        end
    endtask

    task automatic chk_irq(input string req);
        logic exp = (m_pend() != 0);
        n_tests++;
        if (irq_req !== exp) begin
            n_fail++;
            $display("FAIL %s irq actual=%b expected=%b", req, irq_req, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        step(src_lvl, 1'b1, a, d);
    endtask

    initial begin
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        for (int i = 0; i < 32; i++) m_cfg[i] = '0;
        m_en = '0; m_sw = '0; m_raw = '0; m_base = '0; m_stride = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 48; a++) chk_rd(6'(a), "R1");
        chk_irq("R1");

        // R2 config words truncate to 13 bits
        wr(6'd0, 32'hFFFF_FFFF);
        wr(6'd31, 32'h1234_5678);
        chk_rd(6'd0, "R2");
        chk_rd(6'd31, "R2");

        // R3 enable direct/set/clear
        wr(6'd32, 32'h0000_00F0);
        wr(6'd33, 32'h0000_0003);
        chk_rd(6'd32, "R3");
        wr(6'd34, 32'h0000_0011);
        chk_rd(6'd32, "R3");

        // R4 software direct/set/clear, R9 request
        wr(6'd37, 32'h0000_0100);
        wr(6'd38, 32'h0000_0060);
        chk_rd(6'd37, "R4");
        chk_rd(6'd41, "R9");
        chk_irq("R9");
        wr(6'd39, 32'h0000_0060);
        chk_rd(6'd37, "R4");
        chk_rd(6'd35, "R6");

        // R5 hardware levels, one edge later; R7 lowest wins
        step(32'h8000_0404, 1'b0, 6'd0, 32'd0);
        chk_rd(6'd36, "R5");
        wr(6'd32, 32'hFFFF_FFFF);
        chk_rd(6'd41, "R7");
        chk_rd(6'd35, "R6");

        // R8 vector address with stride and base, wraparound
        wr(6'd42, 32'hFFFF_FF00);
        wr(6'd40, 32'hFFFF_FFFF);
        chk_rd(6'd40, "R8");
        chk_rd(6'd43, "R8");
        wr(6'd40, 32'd0);
        chk_rd(6'd43, "R8");

        // R11 read-only offsets and unmapped space
        wr(6'd35, 32'hFFFF_FFFF);
        wr(6'd36, 32'h0);
        wr(6'd41, 32'h0);
        wr(6'd43, 32'h1);
        wr(6'd50, 32'hDEAD_BEEF);
        chk_rd(6'd35, "R11");
        chk_rd(6'd36, "R11");
        chk_rd(6'd42, "R11");
        chk_rd(6'd50, "R11");

        // R10 nothing pending
        wr(6'd32, 32'd0);
        chk_rd(6'd41, "R10");
        chk_rd(6'd43, "R10");
        chk_irq("R10");

        // Random mix: R6 R7 R8 R9 R10
        for (int it = 0; it < 400; it++) begin
            logic [31:0] lvl = ($urandom % 4 == 0) ? $urandom : (src_lvl & $urandom);
            logic [5:0]  a   = ($urandom % 3 == 0) ? 6'($urandom % 64) : 6'(32 + $urandom % 12);
            logic [31:0] d   = ($urandom % 2) ? $urandom : (32'd1 << ($urandom % 32));
            step(lvl, 1'($urandom % 4 != 0), a, d);
            chk_rd(6'd35, "R6");
            chk_rd(6'd41, "R9");
            chk_rd(6'd43, "R8");
            chk_rd(6'($urandom % 64), "R11");
            chk_irq("R10");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule